// File: doc/BRIEF.md
# Standby Mode Clock Controller

This block decides which clocks of a small microcontroller run at any moment. Software writes a clock control word. Two of its bits request one of two low-power modes, and the low bits pick the CPU clock rate. In the light-sleep mode (HALT) only the CPU clock is gated. The oscillator, the interval timer, the clock output and the serial interface keep running, and any interrupt source whose request and enable flags are both set wakes the CPU. In the deep-sleep mode (STOP) the oscillator is switched off and every clock is gated. The one exception is the serial interface, which keeps its clock when it is fed from an external serial clock. Interrupts cannot end STOP. Only the reset input does.

Reset always passes through an oscillator settling phase. The CPU clock stays gated for `SETTLE_CYC` cycles before the block enters normal running, and this covers the restart after STOP. A change of the CPU rate code is not applied at once. It takes effect `DIV_LAG` cycles after the write, and `div_pending` is high during that wait. Entering or leaving a low-power mode leaves the rate code and the countdown untouched.

The state machine has four states: `MODE_RUN`, `MODE_HALT`, `MODE_STOP` and `MODE_SETTLE`. Its named transitions are:
- stop-enter: RUN to STOP.
- halt-enter: RUN to HALT.
- halt-bypass: RUN stays in RUN when HALT is written while a wake is already pending.
- halt-wake: HALT to RUN.
- reset-any: any state to SETTLE.
- settle-done: SETTLE to RUN.

Top module: `stby_clk_ctrl`

## Requirements
- R1: While reset is low and for `SETTLE_CYC` rising edges after it is released, `mode` = 11, `osc_en` = 1 and `cpu_clk_en`, `tmr_clk_en` and `clkout_en` are 0. After those edges `mode` = 00 and all five enables are 1.
- R2: In RUN, a write with bit 3 (`ctl_wdata[DIV_W+1]`) set gives `mode` = 10 after the next edge. This holds even when bit 2 is also set.
- R3: In STOP, `osc_en`, `cpu_clk_en`, `tmr_clk_en` and `clkout_en` are 0, and `sio_clk_en` equals `sio_ext_clk`.
- R4: STOP is not left on any interrupt request and enable pattern. Only a reset ends it, and the block then goes through the R1 settling phase.
- R5: In RUN, a write with bit 2 set and bit 3 clear, made with no source both requested and enabled, gives `mode` = 01 after the next edge. In HALT, `cpu_clk_en` = 0 while `osc_en`, `tmr_clk_en`, `clkout_en` and `sio_clk_en` are 1.
- R6: HALT returns to RUN on the edge after any index i has both `irq_req[i]` and `irq_en[i]` high. A request without its enable, or an enable without its request, does not wake it.
- R7: A HALT write made while a requested and enabled source exists leaves `mode` at 00.
- R8: `ctl_rdata` bit 3 reads 1 only in STOP and bit 2 only in HALT, so both clear once the mode is left. Bits 1:0 read the last accepted rate code. All bits are 0 after reset.
- R9: An accepted write changes `cpu_div_sel` to its bits 1:0 exactly `DIV_LAG` edges after the write edge. `div_pending` is 1 in between. A new write restarts the wait, and the countdown keeps running in HALT.
- R10: Writes made outside RUN are ignored: `mode`, `ctl_rdata` and `cpu_div_sel` are unaffected.
- R11: `mode` encodes run as 00, HALT as 01, STOP as 10 and settling as 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-derived clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr | input | 1 | Single-cycle write strobe for the control word |
| ctl_wdata | input | DIV_W+2 | Control word: bit 3 STOP, bit 2 HALT, bits 1:0 rate code |
| irq_req | input | N_IRQ | Interrupt request flags |
| irq_en | input | N_IRQ | Interrupt enable flags |
| sio_ext_clk | input | 1 | Serial interface takes its clock from an external pin |
| osc_en | output | 1 | Oscillator enable |
| cpu_clk_en | output | 1 | CPU clock enable |
| tmr_clk_en | output | 1 | Interval timer clock enable |
| clkout_en | output | 1 | Clock output circuit enable |
| sio_clk_en | output | 1 | Serial interface clock enable |
| cpu_div_sel | output | DIV_W | CPU rate code in effect |
| div_pending | output | 1 | A rate change is waiting out its lag |
| ctl_rdata | output | DIV_W+2 | Control word readback |
| mode | output | 2 | Current mode (R11 encoding) |

## Verification
The properties take for granted that reset is low at time zero and that `ctl_wr` is a one-cycle strobe. They also assume that the interrupt flags and the serial source select are synchronous to `clk`, so the wake condition seen at an edge is the one the design acts on. The bench changes every input only at falling edges. It holds reset across at least two edges, and it pulses `ctl_wr` for exactly one cycle per write. It changes `sio_ext_clk` only while in STOP, where the bench reads the combinational gate directly.

// File: rtl/stby_pkg.sv
package stby_pkg;

    typedef enum logic [1:0] {
        MODE_RUN    = 2'b00,
        MODE_HALT   = 2'b01,
        MODE_STOP   = 2'b10,
        MODE_SETTLE = 2'b11
    } stby_mode_e;

endpackage

// File: rtl/stby_mode_fsm.sv
module stby_mode_fsm
    import stby_pkg::*;
#(
    parameter int SETTLE_CYC = 256
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_stop,
    input  logic       req_halt,
    input  logic       wake,
    output stby_mode_e mode_q
);

    localparam int CNT_W = $clog2(SETTLE_CYC + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SETTLE_CYC - 1);

    stby_mode_e       mode_d;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_d;
    logic             settle_done;

    assign settle_done = (cnt_q == CNT_LAST);

    // Next-state decision
    always_comb begin
        mode_d = mode_q;
        unique case (mode_q)
            MODE_RUN: begin
                if (req_stop) begin
                    mode_d = MODE_STOP;                     // stop-enter
                end else if (req_halt && !wake) begin
                    mode_d = MODE_HALT;                     // halt-enter
                end                                         // else halt-bypass
            end
            MODE_HALT: begin
                if (wake) mode_d = MODE_RUN;                // halt-wake
            end
            MODE_STOP: begin
                mode_d = MODE_STOP;                         // only reset-any leaves
            end
            MODE_SETTLE: begin
                if (settle_done) mode_d = MODE_RUN;         // settle-done
            end
        endcase
    end

    // Settling counter runs only inside SETTLE
    always_comb begin
        cnt_d = '0;
        if (mode_q == MODE_SETTLE && !settle_done) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    // State register (reset-any lands in SETTLE)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= MODE_SETTLE;
            cnt_q  <= '0;
        end else begin
            mode_q <= mode_d;
            cnt_q  <= cnt_d;
        end
    end

endmodule

// File: rtl/stby_div_lag.sv
module stby_div_lag #(
    parameter int DIV_W   = 2,
    parameter int DIV_LAG = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [DIV_W-1:0] load_val,
    input  logic             count_en,
    output logic [DIV_W-1:0] req_q,
    output logic [DIV_W-1:0] sel_q,
    output logic             pending
);

    localparam int LAG_W = $clog2(DIV_LAG + 1);
    localparam logic [LAG_W-1:0] LAG_INIT = LAG_W'(DIV_LAG);

    logic [LAG_W-1:0] lag_q;
    logic [LAG_W-1:0] lag_d;
    logic [DIV_W-1:0] req_d;
    logic [DIV_W-1:0] sel_d;

    always_comb begin
        lag_d = lag_q;
        req_d = req_q;
        sel_d = sel_q;
        if (load) begin
            req_d = load_val;
            lag_d = LAG_INIT;
        end else if (count_en && lag_q != '0) begin
            if (lag_q == LAG_W'(1)) begin
                sel_d = req_q;
            end
            lag_d = lag_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lag_q <= '0;
            req_q <= '0;
            sel_q <= '0;
        end else begin
            lag_q <= lag_d;
            req_q <= req_d;
            sel_q <= sel_d;
        end
    end

    assign pending = (lag_q != '0);

endmodule

// File: rtl/stby_clk_gate.sv
module stby_clk_gate
    import stby_pkg::*;
(
    input  stby_mode_e mode,
    input  logic       sio_ext_clk,
    output logic       osc_en,
    output logic       cpu_en,
    output logic       tmr_en,
    output logic       clkout_en,
    output logic       sio_en
);

    // Output decode, one process
    always_comb begin
        osc_en    = 1'b1;
        cpu_en    = 1'b1;
        tmr_en    = 1'b1;
        clkout_en = 1'b1;
        sio_en    = 1'b1;
        unique case (mode)
            MODE_RUN: begin
            end
            MODE_HALT: begin
                cpu_en = 1'b0;
            end
            MODE_STOP: begin
                osc_en    = 1'b0;
                cpu_en    = 1'b0;
                tmr_en    = 1'b0;
                clkout_en = 1'b0;
                sio_en    = sio_ext_clk;
            end
            MODE_SETTLE: begin
                cpu_en    = 1'b0;
                tmr_en    = 1'b0;
                clkout_en = 1'b0;
                sio_en    = sio_ext_clk;
            end
        endcase
    end

endmodule

// File: rtl/stby_clk_ctrl.sv
module stby_clk_ctrl
    import stby_pkg::*;
#(
    parameter int N_IRQ      = 4,
    parameter int DIV_W      = 2,
    parameter int DIV_LAG    = 4,
    parameter int SETTLE_CYC = 256
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ctl_wr,
    input  logic [DIV_W+1:0]   ctl_wdata,
    input  logic [N_IRQ-1:0]   irq_req,
    input  logic [N_IRQ-1:0]   irq_en,
    input  logic               sio_ext_clk,
    output logic               osc_en,
    output logic               cpu_clk_en,
    output logic               tmr_clk_en,
    output logic               clkout_en,
    output logic               sio_clk_en,
    output logic [DIV_W-1:0]   cpu_div_sel,
    output logic               div_pending,
    output logic [DIV_W+1:0]   ctl_rdata,
    output logic [1:0]         mode
);

    localparam int STOP_BIT = DIV_W + 1;
    localparam int HALT_BIT = DIV_W;

    stby_mode_e       mode_q;
    logic             wr_ok;
    logic             wake;
    logic [DIV_W-1:0] div_req;

    assign wake  = |(irq_req & irq_en);
    assign wr_ok = ctl_wr && (mode_q == MODE_RUN);

    stby_mode_fsm #(
        .SETTLE_CYC (SETTLE_CYC)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_stop (wr_ok && ctl_wdata[STOP_BIT]),
        .req_halt (wr_ok && ctl_wdata[HALT_BIT]),
        .wake     (wake),
        .mode_q   (mode_q)
    );

    stby_div_lag #(
        .DIV_W   (DIV_W),
        .DIV_LAG (DIV_LAG)
    ) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (wr_ok),
        .load_val (ctl_wdata[DIV_W-1:0]),
        .count_en (osc_en),
        .req_q    (div_req),
        .sel_q    (cpu_div_sel),
        .pending  (div_pending)
    );

    stby_clk_gate u_gate (
        .mode        (mode_q),
        .sio_ext_clk (sio_ext_clk),
        .osc_en      (osc_en),
        .cpu_en      (cpu_clk_en),
        .tmr_en      (tmr_clk_en),
        .clkout_en   (clkout_en),
        .sio_en      (sio_clk_en)
    );

    assign ctl_rdata = {mode_q == MODE_STOP, mode_q == MODE_HALT, div_req};
    assign mode      = mode_q;

endmodule

// File: rtl/stby_chk.sv
module stby_chk #(
    parameter int N_IRQ = 4,
    parameter int DIV_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ctl_wr,
    input logic [DIV_W+1:0] ctl_wdata,
    input logic [N_IRQ-1:0] irq_req,
    input logic [N_IRQ-1:0] irq_en,
    input logic             sio_ext_clk,
    input logic             osc_en,
    input logic             cpu_clk_en,
    input logic             tmr_clk_en,
    input logic             clkout_en,
    input logic             sio_clk_en,
    input logic [DIV_W-1:0] cpu_div_sel,
    input logic             div_pending,
    input logic [DIV_W+1:0] ctl_rdata,
    input logic [1:0]       mode
);

    logic wake_c;
    assign wake_c = |(irq_req & irq_en);

    assert_stop_enter_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b00 && ctl_wr && ctl_wdata[DIV_W+1]) |=> mode == 2'b10);

    assert_stop_gates_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mode == 2'b10 |-> (!osc_en && !cpu_clk_en && !tmr_clk_en && !clkout_en
                           && sio_clk_en == sio_ext_clk));

    assert_stop_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mode == 2'b10 |=> mode == 2'b10);

    assert_halt_gates_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mode == 2'b01 |-> (!cpu_clk_en && osc_en && tmr_clk_en && clkout_en && sio_clk_en));

    assert_halt_wake_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b01 && wake_c) |=> mode == 2'b00);

    assert_halt_bypass_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b00 && ctl_wr && ctl_wdata[DIV_W] && !ctl_wdata[DIV_W+1] && wake_c)
        |=> mode == 2'b00);

    assert_settle_gates_R1: assert property (@(posedge clk) disable iff (!rst_n)
        mode == 2'b11 |-> (osc_en && !cpu_clk_en));

    assert_settle_exit_R1: assert property (@(posedge clk) disable iff (!rst_n)
        mode == 2'b11 |=> (mode == 2'b11 || mode == 2'b00));

    assert_div_change_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_div_sel != $past(cpu_div_sel)) |-> $past(div_pending));

    assert_ignored_wr_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != 2'b00 && ctl_wr) |=> $stable(ctl_rdata[DIV_W-1:0]));

endmodule

bind stby_clk_ctrl stby_chk #(
    .N_IRQ (N_IRQ),
    .DIV_W (DIV_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctl_wr      (ctl_wr),
    .ctl_wdata   (ctl_wdata),
    .irq_req     (irq_req),
    .irq_en      (irq_en),
    .sio_ext_clk (sio_ext_clk),
    .osc_en      (osc_en),
    .cpu_clk_en  (cpu_clk_en),
    .tmr_clk_en  (tmr_clk_en),
    .clkout_en   (clkout_en),
    .sio_clk_en  (sio_clk_en),
    .cpu_div_sel (cpu_div_sel),
    .div_pending (div_pending),
    .ctl_rdata   (ctl_rdata),
    .mode        (mode)
);

// File: tb/stby_clk_ctrl_tb.sv
module stby_clk_ctrl_tb;

    localparam int N_IRQ  = 4;
    localparam int DIV_W  = 2;
    localparam int LAG    = 4;
    localparam int SETTLE = 12;

    // {irq_req, irq_en, expect_wake}
    localparam logic [8:0] HALT_VEC [6] = '{
        {4'b0001, 4'b0001, 1'b1},
        {4'b1000, 4'b1000, 1'b1},
        {4'b0100, 4'b0010, 1'b0},
        {4'b1111, 4'b0000, 1'b0},
        {4'b0000, 4'b1111, 1'b0},
        {4'b0110, 4'b0100, 1'b1}
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             ctl_wr = 1'b0;
    logic [3:0]       ctl_wdata = '0;
    logic [N_IRQ-1:0] irq_req = '0;
    logic [N_IRQ-1:0] irq_en = '0;
    logic             sio_ext_clk = 1'b0;
    logic             osc_en, cpu_clk_en, tmr_clk_en, clkout_en, sio_clk_en;
    logic [DIV_W-1:0] cpu_div_sel;
    logic             div_pending;
    logic [3:0]       ctl_rdata;
    logic [1:0]       mode;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    stby_clk_ctrl #(
        .N_IRQ      (N_IRQ),
        .DIV_W      (DIV_W),
        .DIV_LAG    (LAG),
        .SETTLE_CYC (SETTLE)
    ) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .ctl_wr      (ctl_wr),
        .ctl_wdata   (ctl_wdata),
        .irq_req     (irq_req),
        .irq_en      (irq_en),
        .sio_ext_clk (sio_ext_clk),
        .osc_en      (osc_en),
        .cpu_clk_en  (cpu_clk_en),
        .tmr_clk_en  (tmr_clk_en),
        .clkout_en   (clkout_en),
        .sio_clk_en  (sio_clk_en),
        .cpu_div_sel (cpu_div_sel),
        .div_pending (div_pending),
        .ctl_rdata   (ctl_rdata),
        .mode        (mode)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] d);
        ctl_wr    = 1'b1;
        ctl_wdata = d;
        @(negedge clk);
        ctl_wr    = 1'b0;
        ctl_wdata = '0;
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // enables packed as {osc,cpu,tmr,clkout,sio}
    function automatic logic [7:0] en_vec();
        return {3'b000, osc_en, cpu_clk_en, tmr_clk_en, clkout_en, sio_clk_en};
    endfunction

    task automatic reset_and_settle();
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        chk("R4 async reset to settle", {6'd0, mode}, 8'h03);
        cyc(2);
        rst_n = 1'b1;
        cyc(SETTLE);
        chk("R4 run after settle", {6'd0, mode}, 8'h00);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog act=hung exp=done");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        // R1: reset and settling
        cyc(3);
        chk("R1 mode in reset", {6'd0, mode}, 8'h03);
        chk("R1 enables in reset", en_vec(), 8'b10000);
        chk("R8 rdata after reset", {4'd0, ctl_rdata}, 8'h00);
        rst_n = 1'b1;
        cyc(SETTLE - 1);
        chk("R1 still settling", {6'd0, mode}, 8'h03);
        chk("R1 cpu gated while settling", {7'd0, cpu_clk_en}, 8'h00);
        cyc(1);
        chk("R1 R11 run after settle", {6'd0, mode}, 8'h00);
        chk("R1 all enables in run", en_vec(), 8'b11111);

        // R9: rate change lag
        wr(4'b0010);
        chk("R9 pending after write", {7'd0, div_pending}, 8'h01);
        chk("R8 rdata rate code", {4'd0, ctl_rdata}, 8'h02);
        cyc(LAG - 1);
        chk("R9 old rate before lag", {6'd0, cpu_div_sel}, 8'h00);
        cyc(1);
        chk("R9 new rate after lag", {6'd0, cpu_div_sel}, 8'h02);
        chk("R9 pending cleared", {7'd0, div_pending}, 8'h00);
        wr(4'b0011);
        cyc(1);
        wr(4'b0001);
        cyc(LAG - 1);
        chk("R9 restart keeps old rate", {6'd0, cpu_div_sel}, 8'h02);
        cyc(1);
        chk("R9 restarted rate", {6'd0, cpu_div_sel}, 8'h01);

        // R5 R6: HALT wake vectors
        for (int v = 0; v < 6; v++) begin
            wr(4'b0101);
            chk("R5 HALT entered", {6'd0, mode}, 8'h01);
            chk("R5 HALT enables", en_vec(), 8'b10111);
            irq_req = HALT_VEC[v][8:5];
            irq_en  = HALT_VEC[v][4:1];
            cyc(1);
            chk("R6 HALT wake vector", {6'd0, mode}, HALT_VEC[v][0] ? 8'h00 : 8'h01);
            irq_req = '0;
            irq_en  = '0;
            if (mode != 2'b00) begin
                irq_req = 4'b0001;
                irq_en  = 4'b0001;
                cyc(1);
                irq_req = '0;
                irq_en  = '0;
            end
            cyc(LAG);
        end
        chk("R9 rate kept through HALT", {6'd0, cpu_div_sel}, 8'h01);

        // R7: HALT write with wake already pending
        irq_req = 4'b0010;
        irq_en  = 4'b0010;
        wr(4'b0101);
        chk("R7 HALT bypassed", {6'd0, mode}, 8'h00);
        chk("R7 cpu clock on", {7'd0, cpu_clk_en}, 8'h01);
        irq_req = '0;
        irq_en  = '0;

        // R10 R8: writes ignored in HALT, bits self-clear
        wr(4'b0101);
        wr(4'b1011);
        chk("R10 HALT ignores write mode", {6'd0, mode}, 8'h01);
        chk("R10 R8 HALT rdata", {4'd0, ctl_rdata}, 8'h05);
        irq_req = 4'b0100;
        irq_en  = 4'b0100;
        cyc(1);
        irq_req = '0;
        irq_en  = '0;
        chk("R8 HALT bit self-clears", {4'd0, ctl_rdata}, 8'h01);
        cyc(LAG);

        // R2 R3 R4: STOP
        wr(4'b1001);
        chk("R2 STOP entered", {6'd0, mode}, 8'h02);
        chk("R8 STOP rdata", {4'd0, ctl_rdata}, 8'h09);
        chk("R3 STOP gates internal sio", en_vec(), 8'b00000);
        sio_ext_clk = 1'b1;
        #1;
        chk("R3 STOP external sio", en_vec(), 8'b00001);
        irq_req = 4'b1111;
        irq_en  = 4'b1111;
        cyc(5);
        chk("R4 STOP ignores interrupts", {6'd0, mode}, 8'h02);
        irq_req = '0;
        irq_en  = '0;
        wr(4'b0100);
        chk("R10 STOP ignores write", {4'd0, ctl_rdata}, 8'h09);
        sio_ext_clk = 1'b0;
        reset_and_settle();
        chk("R8 STOP bit cleared after reset", {4'd0, ctl_rdata}, 8'h00);

        // R2: both mode bits means STOP
        wr(4'b1100);
        chk("R2 both bits give STOP", {6'd0, mode}, 8'h02);
        reset_and_settle();

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule